// File: doc/BRIEF.md
# Bitmap Sequence Trigger Handshake Engine

This block is a bus master that asks a remote sequencer to run a series of numbered sequences. A caller gives it an 8-bit request map and pulses `start`. The engine then takes each set bit in turn. For each one it flags the request, fires a trigger and polls a status byte until the sequencer answers. The answer is either that bit in the status byte (acknowledge) or a status of all ones (reject). All traffic to the remote side goes over a byte-wide register bus with a request/acknowledge handshake. Changes to single bits are made as read-modify-write pairs.

Three remote registers sit at fixed offsets above a base address: trigger control at 0x42, request flags at 0x50 and status at 0x51. The engine reports one result code per operation. Whatever the result, once it has begun walking the map it drops every requested flag with one final masked write. Only then does it pulse `done`.

Top module: `seq_trig_engine`

## Requirements
- R1: A `start` with an all-zero `req_map` makes no bus access. `done` is high in the next cycle with `err_code` = 1 (invalid), and `busy` stays low.
- R2: The first access of an accepted operation is a read of status (offset 0x51). If it returns 0xFF, the next access writes 0x00 to status.
- R3: Set bits of the map are handled one at a time, in order from bit 0 to bit 7. Clear bits cause no trigger.
- R4: For each handled bit the engine makes six changes in this order: clear the bit in status, set it in request (0x50), set bit 7 of trigger control (0x42), poll status until the bit reads set, clear it in request, then clear it in status.
- R5: Every bit change is a read of the register followed by a write of the value read with only the masked bits changed. All other bits of that register keep their value.
- R6: A poll that reads exactly 0xFF is followed by a write of 0x00 to status. The operation then ends with `err_code` = 2 (reject), and no later bits are triggered.
- R7: Polls are spaced by at least POLL_GAP idle cycles. After POLL_LIMIT polls with the bit still clear, the operation ends with `err_code` = 3 (timeout) and no later bits are triggered.
- R8: Every operation that read status ends with a read of the request register followed by one write that clears all bits of the original map there. `err_code` is 0 when every bit was acknowledged.
- R9: `done` is high for exactly one cycle, the cycle after the final write is acknowledged. `busy` is low in that cycle, and `err_code` holds its value until the next accepted start.
- R10: `start` is ignored while `busy` or `done` is high.
- R11: Once `bus_req` is raised, it stays high with address, direction and write data unchanged until `bus_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation with `req_map` |
| req_map | input | 8 | Bitmap of sequences to run |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_code | output | 2 | 0 ok, 1 invalid, 2 reject, 3 timeout |
| bus_req | output | 1 | Bus access request, held until acknowledged |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Register address (base plus offset) |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access complete |

## Verification
The assertions check on every cycle that the bus handshake holds still while it waits, that no access is made while idle, and that `done` is a single pulse with `busy` low. They also check that each write to trigger control carries bit 7, and that an empty map is rejected in one cycle. Other behaviours only show up across a whole scenario, and only the bench's remote-sequencer model can expose them: the ascending bit order, the six-step order per bit, how the masked writes leave other bits alone, the poll count and spacing before a timeout, the early stop on a reject, and the final cleanup value.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;

    localparam int MAP_W  = 8;
    localparam int DATA_W = 8;

    localparam logic [7:0] OFS_TRIG  = 8'h42;
    localparam logic [7:0] OFS_REQ   = 8'h50;
    localparam logic [7:0] OFS_STAT  = 8'h51;
    localparam logic [7:0] TRIG_MASK = 8'h80;
    localparam logic [7:0] STAT_FAIL = 8'hFF;

    typedef enum logic [1:0] {
        ERR_OK, ERR_INVALID, ERR_NACK, ERR_TIMEOUT
    } err_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE_RD, ST_PRE_CLR, ST_NEXT, ST_RMW_RD,
        ST_RMW_WR, ST_POLL_RD, ST_POLL_WAIT, ST_NACK_CLR
    } state_e;

    typedef enum logic [2:0] {
        OP_STAT_CLR, OP_REQ_SET, OP_TRIG_SET, OP_REQ_CLR, OP_STAT_DONE, OP_FINAL
    } op_e;

    typedef enum logic [1:0] {MS_BIT, MS_TRIG, MS_MAP} mask_sel_e;

    typedef struct packed {
        logic [7:0] ofs;
        logic       set;
        mask_sel_e  msel;
    } op_desc_t;

    function automatic op_desc_t describe(input op_e op);
        op_desc_t d;
        case (op)
            OP_STAT_CLR, OP_STAT_DONE: d = '{OFS_STAT, 1'b0, MS_BIT};
            OP_REQ_SET:                d = '{OFS_REQ,  1'b1, MS_BIT};
            OP_TRIG_SET:               d = '{OFS_TRIG, 1'b1, MS_TRIG};
            OP_REQ_CLR:                d = '{OFS_REQ,  1'b0, MS_BIT};
            default:                   d = '{OFS_REQ,  1'b0, MS_MAP};
        endcase
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                                input logic [DATA_W-1:0] mask,
                                                input logic              set);
        return set ? (old | mask) : (old & ~mask);
    endfunction

endpackage

// File: rtl/pick_lowest.sv
module pick_lowest #(
    parameter int W = 8
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] onehot,
    output logic         any
);
    assign onehot = vec & (~vec + W'(1));
    assign any    = |vec;
endmodule

// File: rtl/poll_pacer.sv
module poll_pacer #(
    parameter int LIMIT = 2000,
    parameter int GAP   = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic note,
    input  logic waiting,
    output logic last_try,
    output logic gap_done
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam int GW = $clog2(GAP + 1);

    logic [TW-1:0] tries_q;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || arm) tries_q <= '0;
        else if (note)  tries_q <= tries_q + TW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || !waiting) gap_q <= '0;
        else                 gap_q <= gap_q + GW'(1);
    end

    assign last_try = (tries_q == TW'(LIMIT - 1));
    assign gap_done = waiting && (gap_q == GW'(GAP - 1));
endmodule

// File: rtl/seq_trig_engine.sv
module seq_trig_engine
    import seq_trig_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BASE       = 'h0A00,
    parameter int                POLL_LIMIT = 2000,
    parameter int                POLL_GAP   = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MAP_W-1:0]  req_map,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);
    state_e             state_q;
    op_e                op_q;
    logic [MAP_W-1:0]   map_q, pend_q, bit_q, next_oh;
    logic [DATA_W-1:0]  old_q, mask;
    err_e               err_q;
    logic               done_q, pend_any, last_try, gap_done;
    op_desc_t           desc;
    logic [7:0]         ofs;

    pick_lowest #(.W(MAP_W)) u_pick (
        .vec(pend_q), .onehot(next_oh), .any(pend_any)
    );

    poll_pacer #(.LIMIT(POLL_LIMIT), .GAP(POLL_GAP)) u_pacer (
        .clk(clk), .rst(rst),
        .arm(state_q == ST_RMW_WR && bus_ack && op_q == OP_TRIG_SET),
        .note(state_q == ST_POLL_RD && bus_ack),
        .waiting(state_q == ST_POLL_WAIT),
        .last_try(last_try), .gap_done(gap_done)
    );

    always_comb begin
        desc = describe(op_q);
        case (desc.msel)
            MS_TRIG: mask = TRIG_MASK;
            MS_MAP:  mask = map_q;
            default: mask = bit_q;
        endcase
        ofs       = (state_q == ST_RMW_RD || state_q == ST_RMW_WR) ? desc.ofs : OFS_STAT;
        bus_addr  = BASE + ADDR_W'(ofs);
        bus_we    = (state_q == ST_PRE_CLR) || (state_q == ST_RMW_WR) || (state_q == ST_NACK_CLR);
        bus_wdata = (state_q == ST_RMW_WR) ? merge(old_q, mask, desc.set) : '0;
        bus_req   = (state_q != ST_IDLE) && (state_q != ST_NEXT) && (state_q != ST_POLL_WAIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_STAT_CLR;
            map_q   <= '0;
            pend_q  <= '0;
            bit_q   <= '0;
            old_q   <= '0;
            err_q   <= ERR_OK;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start && !done_q) begin
                    if (req_map == '0) begin
                        err_q  <= ERR_INVALID;
                        done_q <= 1'b1;
                    end else begin
                        map_q   <= req_map;
                        pend_q  <= req_map;
                        err_q   <= ERR_OK;
                        state_q <= ST_PRE_RD;
                    end
                end
                ST_PRE_RD: if (bus_ack)
                    state_q <= (bus_rdata == STAT_FAIL) ? ST_PRE_CLR : ST_NEXT;
                ST_PRE_CLR: if (bus_ack) state_q <= ST_NEXT;
                ST_NEXT: begin
                    if (pend_any) begin
                        bit_q  <= next_oh;
                        pend_q <= pend_q & ~next_oh;
                        op_q   <= OP_STAT_CLR;
                    end else begin
                        op_q   <= OP_FINAL;
                    end
                    state_q <= ST_RMW_RD;
                end
                ST_RMW_RD: if (bus_ack) begin
                    old_q   <= bus_rdata;
                    state_q <= ST_RMW_WR;
                end
                ST_RMW_WR: if (bus_ack) begin
                    state_q <= ST_RMW_RD;
                    case (op_q)
                        OP_STAT_CLR:  op_q <= OP_REQ_SET;
                        OP_REQ_SET:   op_q <= OP_TRIG_SET;
                        OP_TRIG_SET:  state_q <= ST_POLL_RD;
                        OP_REQ_CLR:   op_q <= OP_STAT_DONE;
                        OP_STAT_DONE: state_q <= ST_NEXT;
                        default: begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    endcase
                end
                ST_POLL_RD: if (bus_ack) begin
                    if (bus_rdata == STAT_FAIL) begin
                        state_q <= ST_NACK_CLR;
                    end else if ((bus_rdata & bit_q) != '0) begin
                        op_q    <= OP_REQ_CLR;
                        state_q <= ST_RMW_RD;
                    end else if (last_try) begin
                        err_q   <= ERR_TIMEOUT;
                        op_q    <= OP_FINAL;
                        state_q <= ST_RMW_RD;
                    end else begin
                        state_q <= ST_POLL_WAIT;
                    end
                end
                ST_POLL_WAIT: if (gap_done) state_q <= ST_POLL_RD;
                ST_NACK_CLR: if (bus_ack) begin
                    err_q   <= ERR_NACK;
                    op_q    <= OP_FINAL;
                    state_q <= ST_RMW_RD;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign err_code = err_q;
endmodule

// File: rtl/seq_trig_checker.sv
module seq_trig_checker #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE   = 'h0A00
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [7:0]        req_map,
    input logic              busy,
    input logic              done,
    input logic [1:0]        err_code,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_ack
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req); // R1
    AST_ZERO_MAP: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done && req_map == 8'h00) |=> (done && err_code == 2'd1 && !busy)); // R1
    AST_TRIG_BIT: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == BASE + ADDR_W'(8'h42)) |-> bus_wdata[7]); // R5
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(err_code)); // R9
    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))); // R11
endmodule

bind seq_trig_engine seq_trig_checker #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
    .clk(clk), .rst(rst), .start(start), .req_map(req_map), .busy(busy),
    .done(done), .err_code(err_code), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/tb_seq_trig_engine.sv
module tb_seq_trig_engine;
    localparam int          LIM  = 5;
    localparam int          GAP  = 3;
    localparam logic [15:0] BASE = 16'h0A00;
    localparam logic [7:0]  O_T = 8'h42, O_Q = 8'h50, O_S = 8'h51;

    logic clk = 0, rst = 1, start = 0;
    logic [7:0] req_map = 0;
    logic busy, done, bus_req, bus_we;
    logic [1:0] err_code;
    logic [15:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata = 0;
    logic bus_ack = 0;

    always #10 clk = ~clk;

    seq_trig_engine #(.ADDR_W(16), .BASE(BASE), .POLL_LIMIT(LIM), .POLL_GAP(GAP)) dut (
        .clk(clk), .rst(rst), .start(start), .req_map(req_map), .busy(busy),
        .done(done), .err_code(err_code), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    int total = 0, fails = 0;
    bit finished = 0;

    // remote register model and sequencer model
    logic [7:0] rg_t, rg_q, rg_s;
    int mode [8];               // 0 ack, 1 reject, 2 silent
    int arm_bit = 0, seq_bit = 0, seq_cnt = 0, dly = 0;
    bit seq_armed = 0;
    logic [7:0] log_o [0:1023];
    bit         log_w [0:1023];
    logic [7:0] log_d [0:1023];
    int log_n = 0, trig_n = 0;
    int trig_l [0:15];
    int poll_n = 0, last_poll = -1, min_gap = 1000000, cyc = 0, hold_viol = 0;
    bit p_pend = 0;
    logic [15:0] p_addr;
    logic [7:0]  p_wd;
    bit          p_we;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    always @(negedge clk) begin
        logic [7:0] o, nb;
        cyc++;
        if (p_pend && (bus_addr != p_addr || bus_we != p_we || bus_wdata != p_wd || !bus_req))
            hold_viol++;
        if (bus_ack) begin
            bus_ack = 0;
        end else if (bus_req) begin
            if (dly > 0) dly--;
            else begin
                o = 8'(bus_addr - BASE);
                log_o[log_n] = o; log_w[log_n] = bus_we; log_d[log_n] = bus_wdata;
                if (log_n < 1023) log_n++;
                if (bus_we) begin
                    if (o == O_Q) begin
                        nb = bus_wdata & ~rg_q;
                        for (int i = 7; i >= 0; i--) if (nb[i]) arm_bit = i;
                        rg_q = bus_wdata;
                    end else if (o == O_S) rg_s = bus_wdata;
                    else if (o == O_T) begin
                        rg_t = bus_wdata;
                        if (bus_wdata[7]) begin
                            seq_armed = 1; seq_bit = arm_bit; seq_cnt = $urandom_range(0, 8);
                            if (trig_n < 16) trig_l[trig_n] = arm_bit;
                            trig_n++;
                            poll_n = 0; last_poll = -1; min_gap = 1000000;
                        end
                    end
                end else begin
                    bus_rdata = (o == O_Q) ? rg_q : (o == O_S) ? rg_s : (o == O_T) ? rg_t : 8'h00;
                    if (o == O_S && trig_n > 0) begin
                        poll_n++;
                        if (last_poll >= 0 && cyc - last_poll < min_gap) min_gap = cyc - last_poll;
                        last_poll = cyc;
                    end
                end
                bus_ack = 1;
                dly = $urandom_range(0, 2);
            end
        end
        p_pend = bus_req && !bus_ack;
        p_addr = bus_addr; p_we = bus_we; p_wd = bus_wdata;
        if (seq_armed) begin
            if (seq_cnt == 0) begin
                seq_armed = 0;
                rg_t[7] = 0;
                if (mode[seq_bit] == 0) rg_s = rg_s | (8'h01 << seq_bit);
                else if (mode[seq_bit] == 1) rg_s = 8'hFF;
            end else seq_cnt--;
        end
    end

    task automatic run_case(input logic [7:0] map, input logic [7:0] s0,
                            input logic [7:0] t0, input logic [7:0] r0,
                            input bit poke_busy, input bit timing);
        int exp_err = 0, en = 0, k, w;
        int el [0:7];
        logic [7:0] p = 0, seff, first;
        seff = (s0 == 8'hFF) ? 8'h00 : s0;
        for (int b = 0; b < 8; b++) if (map[b] && exp_err == 0) begin
            p[b] = 1; el[en] = b; en++;
            if (mode[b] == 1) exp_err = 2;
            else if (mode[b] == 2) exp_err = 3;
        end
        @(negedge clk);
        rg_s = s0; rg_t = t0; rg_q = r0; log_n = 0; trig_n = 0; seq_armed = 0;
        start = 1; req_map = map;
        @(negedge clk); start = 0;
        if (poke_busy) begin
            repeat (3) @(negedge clk);
            start = 1; req_map = ~map;
            @(negedge clk); start = 0;
        end
        w = 0;
        while (!done && w < 20000) begin @(negedge clk); w++; end
        chk(w < 20000, "R9 done seen", w, 0);
        chk(!busy, "R9 busy low with done", busy, 0);
        chk(err_code == 2'(exp_err), "R3/R6/R7/R8 result code", err_code, exp_err);
        chk(trig_n == en, "R3/R10 trigger count", trig_n, en);
        for (int i = 0; i < en && i < trig_n; i++)
            chk(trig_l[i] == el[i], "R3 bit order", trig_l[i], el[i]);
        chk(log_o[0] == O_S && !log_w[0], "R2 first access reads status", log_o[0], O_S);
        if (s0 == 8'hFF) begin
            chk(log_o[1] == O_S && log_w[1] && log_d[1] == 0, "R2 clear stale reject", log_d[1], 0);
            k = 2;
        end else begin
            chk(!log_w[1], "R2 no clear when status ok", log_w[1], 0);
            k = 1;
        end
        first = 8'h01 << el[0];
        chk(log_o[k] == O_S && !log_w[k] && log_o[k+1] == O_S && log_w[k+1] &&
            log_o[k+2] == O_Q && !log_w[k+2] && log_o[k+3] == O_Q && log_w[k+3] &&
            log_o[k+4] == O_T && !log_w[k+4] && log_o[k+5] == O_T && log_w[k+5],
            "R4 step order", {log_o[k], log_o[k+2], log_o[k+4]}, {O_S, O_Q, O_T});
        chk(log_d[k+1] == (seff & ~first), "R5 status clear keeps others", log_d[k+1], seff & ~first);
        chk(log_d[k+3] == (r0 | first), "R5 request set keeps others", log_d[k+3], r0 | first);
        chk(log_d[k+5] == (t0 | 8'h80), "R5 trigger keeps others", log_d[k+5], t0 | 8'h80);
        chk(log_o[log_n-2] == O_Q && !log_w[log_n-2] && log_o[log_n-1] == O_Q && log_w[log_n-1] &&
            log_d[log_n-1] == (r0 & ~map), "R8 final cleanup write", log_d[log_n-1], r0 & ~map);
        chk(rg_q == (r0 & ~map), "R8 request register", rg_q, r0 & ~map);
        chk(rg_s == ((exp_err == 2) ? 8'h00 : (seff & ~p)), "R6/R4 status register",
            rg_s, (exp_err == 2) ? 8'h00 : (seff & ~p));
        chk(rg_t[6:0] == t0[6:0], "R5 trigger low bits", rg_t, t0);
        chk(hold_viol == 0, "R11 request held", hold_viol, 0);
        if (timing) begin
            chk(poll_n == LIM, "R7 poll count", poll_n, LIM);
            chk(min_gap >= GAP + 1, "R7 poll spacing", min_gap, GAP + 1);
        end
        @(negedge clk);
        chk(!done, "R9 done single pulse", done, 0);
        chk(err_code == 2'(exp_err), "R9 code held", err_code, exp_err);
    endtask

    initial begin
        process p0;
        logic [7:0] m, s, t, r;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!busy && !done && err_code == 0 && !bus_req, "R9 reset state",
            {busy, done, err_code, bus_req}, 0);
        // R1 empty map
        log_n = 0;
        start = 1; req_map = 8'h00;
        @(negedge clk); start = 0;
        chk(done && err_code == 2'd1 && !busy, "R1 empty map rejected", err_code, 1);
        @(negedge clk);
        chk(log_n == 0, "R1 no bus access", log_n, 0);
        // all acknowledged, stale reject present
        for (int i = 0; i < 8; i++) mode[i] = 0;
        run_case(8'hFF, 8'hFF, 8'h15, 8'h00, 0, 0);
        // timeout on bit 0 stops bit 7
        mode[0] = 2;
        run_case(8'h81, 8'h24, 8'h3C, 8'h42, 0, 1);
        // reject on bit 2, late start while busy ignored (R10)
        for (int i = 0; i < 8; i++) mode[i] = 0;
        mode[2] = 1;
        run_case(8'h0E, 8'h10, 8'h01, 8'h80, 1, 0);
        // constrained random
        for (int n = 0; n < 30; n++) begin
            for (int i = 0; i < 8; i++) begin
                int x = $urandom_range(0, 11);
                mode[i] = (x == 0) ? 1 : (x == 1) ? 2 : 0;
            end
            m = 8'($urandom_range(1, 255));
            s = 8'($urandom) & ~m;
            if ((s | m) == 8'hFF && m != 8'hFF) s = s & ~((~m) & (m + 8'd1));
            if ($urandom_range(0, 5) == 0) s = 8'hFF;
            t = 8'($urandom);
            r = 8'($urandom) & ~m;
            run_case(m, s, t, r, n % 7 == 3, 0);
        end
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            total++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule